// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads one entry from each of four page tables kept in memory, starting from a root table base that software loads for the running process. Each table fills one 4 KiB page. The first level is indexed by the top 6 bits of the page number, and each of the three lower levels by a 10-bit field. Each entry found on the way either points to the next table or, at the last level, gives the physical page frame. The frame is then joined with the 12-bit page offset.

At every level the walker checks three flag bits of the entry: present, writable and user-accessible. The first failed check ends the walk. The walker then reports a fault code and the level where the walk stopped, instead of an address. A write access that succeeds can also write the final entry back with its dirty flag set. The walker uses a single memory port and has at most one access outstanding. A new translation is accepted only when the walker is idle.

Top module: `pgwalk`

## Requirements
- R1: While reset is asserted, and directly after it, `res_valid` is 0, `mem_req` is 0 and `req_ready` is 1.
- R2: The first read goes to the root base plus 4 times `req_vaddr[47:42]`. The read at each lower level goes to the previous entry's frame field (bits 31:12) shifted left by 12, plus 4 times the level's index. These indices are `[41:32]`, `[31:22]` and `[21:12]`, in that order.
- R3: Only one memory access is outstanding at a time. `mem_req` and `mem_addr` are held until `mem_ack`, and a walk with no fault makes exactly four reads.
- R4: When no fault occurs, `res_paddr` equals the final entry's bits 31:12 joined with `req_vaddr[11:0]`, and `res_code` is 0.
- R5: If an entry has bit 0 (present) clear, the walk stops with `res_code` 1. This check comes before the other two, and no further reads follow.
- R6: If a user-mode request (`req_user`=1) reads an entry with bit 2 (user) clear, the walk stops with `res_code` 2. This check ranks above the write check.
- R7: If a write request reads an entry with bit 1 (writable) clear, the walk stops with `res_code` 3. A read request ignores bit 1.
- R8: After a successful write walk whose final entry has bit 6 (dirty) clear, the walker writes the same entry with bit 6 set back to that entry's address. No write-back occurs for read requests or when bit 6 is already set.
- R9: `res_valid` is a single-cycle pulse per translation. On a fault, `res_level` gives the level where the walk stopped, from 0 (root table) to 3 (final table).
- R10: A request is taken only while `req_ready` is 1. A `req_valid` raised during a walk does not change that walk's reads or its result.
- R11: A pulse on `root_we` replaces the root base used by later walks. Entry bits 9 and 10 are stored and written back, but they never change the outcome of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load strobe for the root table base |
| root_base | input | 32 | Root table base address (page aligned) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is the dirty write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 ok, 1 not present, 2 user violation, 3 write violation |
| res_level | output | 2 | Level at which a fault stopped the walk |
| res_paddr | output | 32 | Translated physical address |

## Verification
A result is due one cycle after the edge that accepts the deciding `mem_ack`. That is the last read, the write-back, or the read that faulted. The number of acknowledges before it depends on where the walk stops and on whether a write-back is needed. The memory model in the bench acknowledges after a latency of zero to two extra cycles, which changes from one translation to the next. So the bench does not count a fixed delay. It waits on falling edges for the first `res_valid`, checks the code, level, address and the logged memory traffic there, and checks one falling edge later that the pulse has ended.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WALK,
      ST_WBACK,
      ST_DONE,
      ST_FAULT
   } walk_st_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_USER   = 2'd2,
      FLT_WRITE  = 2'd3
   } fault_e;

   localparam int PTE_PRESENT  = 0;
   localparam int PTE_WRITABLE = 1;
   localparam int PTE_USER     = 2;
   localparam int PTE_DIRTY    = 6;
   localparam int PTE_OS_HI    = 10;

endpackage

// File: rtl/pgw_locator.sv
module pgw_locator #(
   parameter int VPN_W     = 36,
   parameter int TOP_IDX_W = 6,
   parameter int IDX_W     = 10,
   parameter int LEVELS    = 4,
   parameter int LVL_W     = 2,
   parameter int PA_W      = 32,
   parameter int ENT_SHIFT = 2
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] lvl,
   input  logic [PA_W-1:0]  table_base,
   output logic [PA_W-1:0]  entry_addr
);

   logic [IDX_W-1:0] idx_arr [LEVELS];
   logic [IDX_W-1:0] idx_sel;

   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_slice
         if (l == 0) begin : g_top
            assign idx_arr[l] = IDX_W'(vpn[VPN_W-1 -: TOP_IDX_W]);
         end else begin : g_low
            assign idx_arr[l] = vpn[(LEVELS-1-l)*IDX_W +: IDX_W];
         end
      end
   endgenerate

   assign idx_sel    = idx_arr[lvl];
   assign entry_addr = table_base + (PA_W'(idx_sel) << ENT_SHIFT);

endmodule

// File: rtl/pgw_pte_judge.sv
module pgw_pte_judge
   import pgw_pkg::*;
(
   input  logic   present,
   input  logic   writable,
   input  logic   user_ok,
   input  logic   acc_write,
   input  logic   acc_user,
   output fault_e verdict
);

   always_comb begin
      if (!present)
         verdict = FLT_ABSENT;
      else if (acc_user && !user_ok)
         verdict = FLT_USER;
      else if (acc_write && !writable)
         verdict = FLT_WRITE;
      else
         verdict = FLT_NONE;
   end

endmodule

// File: rtl/pgwalk.sv
module pgwalk
   import pgw_pkg::*;
#(
   parameter int   OFF_W        = 12,
   parameter int   TOP_IDX_W    = 6,
   parameter int   IDX_W        = 10,
   parameter int   LEVELS       = 4,
   parameter int   PTE_W        = 32,
   parameter int   PA_W         = 32,
   parameter bit   DIRTY_UPDATE = 1'b1,
   localparam int  VPN_W        = TOP_IDX_W + (LEVELS - 1) * IDX_W,
   localparam int  VA_W         = VPN_W + OFF_W,
   localparam int  LVL_W        = $clog2(LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             root_we,
   input  logic [PA_W-1:0]  root_base,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic             req_user,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic             mem_ack,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic             res_valid,
   output logic [1:0]       res_code,
   output logic [LVL_W-1:0] res_level,
   output logic [PA_W-1:0]  res_paddr
);

   localparam int FRAME_W   = PA_W - OFF_W;
   localparam int ENT_SHIFT = $clog2(PTE_W / 8);
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   // elaboration-time parameter checks
   if (LEVELS < 2) begin : g_chk_levels
      $error("pgwalk: LEVELS must be at least 2");
   end
   if (TOP_IDX_W > IDX_W) begin : g_chk_top
      $error("pgwalk: TOP_IDX_W must not exceed IDX_W");
   end
   if (IDX_W + ENT_SHIFT > OFF_W) begin : g_chk_fit
      $error("pgwalk: one table must fit inside one page");
   end
   if ((PTE_W % 8) != 0 || PTE_W - FRAME_W <= PTE_OS_HI) begin : g_chk_pte
      $error("pgwalk: entry too narrow for frame field plus flag bits");
   end
   if (FRAME_W < 1) begin : g_chk_pa
      $error("pgwalk: PA_W must exceed OFF_W");
   end

   walk_st_e         state_q;
   logic [LVL_W-1:0] lvl_q;
   logic [VA_W-1:0]  va_q;
   logic             write_q;
   logic             user_q;
   logic [PA_W-1:0]  root_q;
   logic [PA_W-1:0]  base_q;
   logic [PTE_W-1:0] ent_q;
   logic [PA_W-1:0]  ent_addr_q;
   fault_e           code_q;
   logic [LVL_W-1:0] flvl_q;
   logic [PA_W-1:0]  paddr_q;

   logic [PA_W-1:0]  loc_addr;
   fault_e           verdict;
   logic             need_wb;
   logic [FRAME_W-1:0] frame_in;

   assign frame_in = mem_rdata[PTE_W-1 -: FRAME_W];

   pgw_locator #(
      .VPN_W     (VPN_W),
      .TOP_IDX_W (TOP_IDX_W),
      .IDX_W     (IDX_W),
      .LEVELS    (LEVELS),
      .LVL_W     (LVL_W),
      .PA_W      (PA_W),
      .ENT_SHIFT (ENT_SHIFT)
   ) u_loc (
      .vpn        (va_q[VA_W-1:OFF_W]),
      .lvl        (lvl_q),
      .table_base (base_q),
      .entry_addr (loc_addr)
   );

   pgw_pte_judge u_judge (
      .present   (mem_rdata[PTE_PRESENT]),
      .writable  (mem_rdata[PTE_WRITABLE]),
      .user_ok   (mem_rdata[PTE_USER]),
      .acc_write (write_q),
      .acc_user  (user_q),
      .verdict   (verdict)
   );

   generate
      if (DIRTY_UPDATE) begin : g_dirty
         assign need_wb = write_q & ~mem_rdata[PTE_DIRTY];
      end else begin : g_no_dirty
         assign need_wb = 1'b0;
      end
   endgenerate

   // root base register
   always_ff @(posedge clk) begin
      if (!rst_n)
         root_q <= '0;
      else if (root_we)
         root_q <= root_base;
   end

   // walk sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         lvl_q      <= '0;
         va_q       <= '0;
         write_q    <= 1'b0;
         user_q     <= 1'b0;
         base_q     <= '0;
         ent_q      <= '0;
         ent_addr_q <= '0;
         code_q     <= FLT_NONE;
         flvl_q     <= '0;
         paddr_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_WALK;
                  lvl_q   <= '0;
                  va_q    <= req_vaddr;
                  write_q <= req_write;
                  user_q  <= req_user;
                  base_q  <= root_q;
                  code_q  <= FLT_NONE;
                  flvl_q  <= '0;
               end
            end
            ST_WALK: begin
               if (mem_ack) begin
                  if (verdict != FLT_NONE) begin
                     code_q  <= verdict;
                     flvl_q  <= lvl_q;
                     state_q <= ST_FAULT;
                  end else if (lvl_q == LAST_LVL) begin
                     paddr_q    <= {frame_in, va_q[OFF_W-1:0]};
                     ent_q      <= mem_rdata;
                     ent_addr_q <= loc_addr;
                     state_q    <= need_wb ? ST_WBACK : ST_DONE;
                  end else begin
                     base_q <= {frame_in, {OFF_W{1'b0}}};
                     lvl_q  <= lvl_q + LVL_W'(1);
                  end
               end
            end
            ST_WBACK: begin
               if (mem_ack)
                  state_q <= ST_DONE;
            end
            ST_DONE:  state_q <= ST_IDLE;
            ST_FAULT: state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_WALK) || (state_q == ST_WBACK);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_addr  = (state_q == ST_WBACK) ? ent_addr_q : loc_addr;
   assign mem_wdata = ent_q | (PTE_W'(1) << PTE_DIRTY);
   assign res_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
   assign res_code  = code_q;
   assign res_level = flvl_q;
   assign res_paddr = paddr_q;

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
   parameter int PA_W      = 32,
   parameter int PTE_W     = 32,
   parameter int DIRTY_BIT = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [PA_W-1:0]  mem_addr,
   input logic [PTE_W-1:0] mem_wdata,
   input logic             res_valid
);

   // R3
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   // R3
   walk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !res_valid);

   // R9
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !res_valid);

   // R8
   wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[DIRTY_BIT]);

   // R8
   wb_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> res_valid);

endmodule

bind pgwalk pgw_chk #(
   .PA_W  (PA_W),
   .PTE_W (PTE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .res_valid (res_valid)
);

// File: tb/sim_pgwalk.sv
`timescale 1ns/1ps
module sim_pgwalk;

   localparam logic [19:0] FINAL_FRAME = 20'h5A5A5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [31:0] root_base = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        res_valid;
   logic [1:0]  res_code;
   logic [1:0]  res_level;
   logic [31:0] res_paddr;

   always #2 clk = ~clk;

   pgwalk u0 (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_base(root_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .res_valid(res_valid), .res_code(res_code), .res_level(res_level),
      .res_paddr(res_paddr)
   );

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [logic [31:0]];
   int          lat = 0;
   int          wait_cnt = 0;
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   logic [31:0] rd_log [0:7];
   logic [31:0] wr_addr = '0;
   logic [31:0] wr_data = '0;

   // memory model with a per-walk latency
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (rst_n && mem_req && !mem_ack) begin
         if (wait_cnt >= lat) begin
            wait_cnt = 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr] = mem_wdata;
               wr_addr = mem_addr;
               wr_data = mem_wdata;
               wr_cnt++;
            end else begin
               mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
               if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
               rd_cnt++;
            end
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic load_root(input logic [31:0] b);
      @(negedge clk);
      root_we = 1'b1;
      root_base = b;
      @(negedge clk);
      root_we = 1'b0;
      root_base = 32'hDEAD_0000;
   endtask

   task automatic walk(input int t, input logic [31:0] rootf,
                       input logic [2:0] f0, input logic [2:0] f1,
                       input logic [2:0] f2, input logic [2:0] f3,
                       input bit dirty, input bit wr, input bit us, input bit junk);
      int i1, i2, i3, i4, off, ecode, elvl, ereads, ewr, n;
      logic [47:0] va;
      logic [31:0] os, fin, tbl [4], frm [4];
      logic [2:0]  fs [4];
      i1  = (t * 7 + 3) % 64;
      i2  = (t * 37 + 11) % 1024;
      i3  = (t * 53 + 500) % 1024;
      i4  = (t * 91 + 77) % 1024;
      off = (t * 13 + 5) % 4096;
      va  = {6'(i1), 10'(i2), 10'(i3), 10'(i4), 12'(off)};
      os  = (t % 2 == 1) ? 32'h600 : 32'h0;
      fs  = '{f0, f1, f2, f3};
      frm = '{rootf, 32'd2, 32'd3, 32'd4};
      tbl[0] = (rootf << 12) + 32'(i1 * 4);
      tbl[1] = (32'd2 << 12) + 32'(i2 * 4);
      tbl[2] = (32'd3 << 12) + 32'(i3 * 4);
      tbl[3] = (32'd4 << 12) + 32'(i4 * 4);
      fin = {FINAL_FRAME, 12'h0} | 32'(f3) | os | (dirty ? 32'h40 : 32'h0);
      mem.delete();
      mem[tbl[0]] = (32'd2 << 12) | 32'(f0) | os;
      mem[tbl[1]] = (32'd3 << 12) | 32'(f1);
      mem[tbl[2]] = (32'd4 << 12) | 32'(f2) | os;
      mem[tbl[3]] = fin;
      // expected outcome from the flag rules, first failing level wins
      ecode = 0;
      elvl  = 0;
      for (int k = 0; k < 4; k++) begin
         if (ecode == 0) begin
            if (!fs[k][0])              ecode = 1;
            else if (us && !fs[k][2])   ecode = 2;
            else if (wr && !fs[k][1])   ecode = 3;
            if (ecode != 0) elvl = k;
         end
      end
      ereads = (ecode != 0) ? elvl + 1 : 4;
      ewr    = (ecode == 0 && wr && !dirty) ? 1 : 0;

      lat = t % 3;
      wait_cnt = 0;
      rd_cnt = 0;
      wr_cnt = 0;
      @(negedge clk);
      chk("R10", "ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      req_user  = us;
      @(negedge clk);
      chk("R10", "ready drops after accept", req_ready, 0);
      if (junk) begin
         req_vaddr = ~va;
         req_write = ~wr;
         req_user  = 1'b0;
      end else begin
         req_valid = 1'b0;
      end
      n = 0;
      while (!res_valid && n < 300) begin
         if (n >= 2) req_valid = 1'b0;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      chk("R9", "result seen", res_valid, 1);
      chk(ecode == 1 ? "R5" : ecode == 2 ? "R6" : ecode == 3 ? "R7" : "R4",
          "fault code", res_code, ecode);
      if (ecode != 0)
         chk("R9", "fault level", res_level, elvl);
      else
         chk("R4", "physical address", res_paddr, {FINAL_FRAME, 12'(off)});
      chk("R3", "read count", rd_cnt, ereads);
      for (int k = 0; k < 4; k++) begin
         if (k < ereads && k < rd_cnt)
            chk(k == 0 ? "R11" : "R2", "entry address", rd_log[k], tbl[k]);
      end
      if (junk) chk("R10", "busy request ignored", rd_cnt, ereads);
      @(negedge clk);
      chk("R9", "pulse ends", res_valid, 0);
      chk("R8", "write-back count", wr_cnt, ewr);
      if (ewr == 1) begin
         chk("R8", "write-back address", wr_addr, tbl[3]);
         chk("R8", "write-back data", wr_data, fin | 32'h40);
      end
      if (frm[0] == 32'hFFFF_FFFF) chk("R2", "unused", 0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "res_valid in reset", res_valid, 0);
      chk("R1", "mem_req in reset", mem_req, 0);
      chk("R1", "req_ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "mem_req after reset", mem_req, 0);
      load_root(32'h0000_1000);
      for (int t = 0; t < 128; t++) begin
         int lv, f;
         logic [2:0] fl [4];
         lv = t / 32;
         f  = (t / 4) % 8;
         fl = '{3'b111, 3'b111, 3'b111, 3'b111};
         fl[lv] = 3'(f);
         if (t == 64) load_root(32'h0000_8000);
         walk(t, (t < 64) ? 32'd1 : 32'd8, fl[0], fl[1], fl[2], fl[3],
              ((t / 3) % 2) == 1, t[0], t[1], (t % 5) == 0);
      end
      // R8: successful write with dirty flag already set, then a read
      walk(200, 32'd8, 3'b111, 3'b111, 3'b111, 3'b111, 1'b1, 1'b1, 1'b0, 1'b0);
      walk(201, 32'd8, 3'b111, 3'b111, 3'b111, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule